// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single atomic reservation of one hardware thread. It sits after address translation and sees only physical addresses plus an uncacheable attribute. A reserve request (the load half of an atomic pair) records which 16-byte granule was read and marks the reservation live. A conditional request (the store half) is judged against that reservation. The block says whether the store may go on to memory and returns a 2-bit result code that the writeback stage uses.

Conditional stores to uncacheable space are not checked. They always proceed with a distinct code that tells writeback to leave the destination register alone. Every failed cacheable conditional store advances a consecutive-failure counter, and a one-cycle warning pulse fires each time that count reaches a multiple of a configured interval, so that livelock can be detected. An invalidate input, driven by a snoop hit or an exception, kills the reservation. All outputs are registered and appear one clock after the request strobe.

Top module: `lrsc_monitor`

## Requirements
- R1: While `rst` is high and in the cycle after it, `res_valid_o`, `issue_ok_o`, `result_o` and `livelock_warn_o` are 0. Reset leaves no live reservation, so the first cacheable conditional store after reset fails.
- R2: A reserve request (`req_op_i`=0) records its address with the low `GRAN_BITS` (default 4) bits dropped and makes the reservation live. A later cacheable conditional store to any byte of that granule returns result 1 with `issue_ok_o`=1.
- R3: A cacheable conditional store (`req_op_i`=1) with no live reservation returns result 0 with `issue_ok_o`=0.
- R4: A cacheable conditional store to a different granule returns result 0 with `issue_ok_o`=0 and kills the reservation, so a following store to the reserved granule also fails.
- R5: A conditional store that issues kills the reservation and resets the failure counter to 0.
- R6: A conditional store with `req_uncached_i`=1 returns result 2 with `issue_ok_o`=1 whatever the reservation state. Because it issues, it obeys R5 as well.
- R7: `res_valid_o` is high for exactly the cycle after each conditional request. It stays low after reserve requests and idle cycles. When it is low, `issue_ok_o` and `result_o` are 0.
- R8: Each failed conditional store adds one to the failure counter. `livelock_warn_o` pulses for one cycle, together with that failure's result, when the new count is a multiple of `WARN_INTERVAL`.
- R9: The failure counter saturates at its all-ones value (15 with `CNT_W`=4). Failures at saturation change nothing and raise no warning.
- R10: `inval_i` kills the reservation. It takes effect before a request in the same cycle: a conditional store in that cycle fails, and a reserve request in that cycle still sets up a live reservation.
- R11: A new reserve request replaces the previous reservation address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_op_i | input | 1 | 0 = reserve, 1 = conditional store |
| req_addr_i | input | ADDR_W | Physical address |
| req_uncached_i | input | 1 | Address is uncacheable |
| inval_i | input | 1 | Kill the reservation (snoop hit or exception) |
| res_valid_o | output | 1 | Conditional-store result is valid |
| issue_ok_o | output | 1 | Store may be sent to memory |
| result_o | output | 2 | 0 = failed, 1 = succeeded, 2 = uncacheable bypass |
| livelock_warn_o | output | 1 | One-cycle pulse at each multiple of the warning interval |

## Verification
The invalidate input and a request can land in the same cycle. The outcome then depends on an ordering rule: the invalidate comes first, so a conditional store in that cycle fails, while a reserve request in that cycle still leaves a live reservation. The stimulus table drives `inval_i` alongside a reserve, alongside a conditional store, and on an idle cycle between a reserve and its conditional store. Each case is judged by the result code of that cycle's store or of the next one. A second collision, between a failure that lands on a warning multiple and the counter reaching saturation, is provoked by a run of 17 straight failures with a small interval.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic {
    OP_RESERVE = 1'b0,
    OP_COND    = 1'b1
  } lrsc_op_e;

  localparam logic [1:0] RES_FAIL   = 2'd0;
  localparam logic [1:0] RES_OK     = 2'd1;
  localparam logic [1:0] RES_BYPASS = 2'd2;
endpackage

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4,
  localparam int TAG_W    = ADDR_W - GRAN_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             kill_i,
  output logic             live_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             live_q;
  logic [TAG_W-1:0] tag_q;

  // A reserve request wins over a kill in the same cycle, because the kill is ordered first.
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      tag_q  <= '0;
    end else if (set_i) begin
      live_q <= 1'b1;
      tag_q  <= set_tag_i;
    end else if (kill_i) begin
      live_q <= 1'b0;
    end
  end

  assign live_o = live_q;
  assign tag_o  = tag_q;
endmodule

// File: rtl/lrsc_judge.sv
module lrsc_judge
  import lrsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4,
  localparam int TAG_W    = ADDR_W - GRAN_BITS
) (
  input  logic             live_i,
  input  logic [TAG_W-1:0] resv_tag_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             uncached_i,
  input  logic             inval_i,
  output logic             pass_o,
  output logic [1:0]       code_o
);
  logic hit;

  // An invalidate in the same cycle hides the reservation from the store.
  assign hit = live_i && !inval_i && (resv_tag_i == req_tag_i);

  always_comb begin
    if (uncached_i) begin
      pass_o = 1'b1;
      code_o = RES_BYPASS;
    end else if (hit) begin
      pass_o = 1'b1;
      code_o = RES_OK;
    end else begin
      pass_o = 1'b0;
      code_o = RES_FAIL;
    end
  end
endmodule

// File: rtl/lrsc_fail_cnt.sv
module lrsc_fail_cnt #(
  parameter int CNT_W         = 17,
  parameter int WARN_INTERVAL = 100000,
  localparam int PH_W         = (WARN_INTERVAL > 1) ? $clog2(WARN_INTERVAL) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_i,
  input  logic clear_i,
  output logic warn_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(WARN_INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic             warn_q;

  // The phase counter stands in for a modulo test on the full count.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ph_q   <= '0;
      warn_q <= 1'b0;
    end else begin
      warn_q <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
        ph_q  <= '0;
      end else if (fail_i && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
        if (ph_q == PH_LAST) begin
          ph_q   <= '0;
          warn_q <= 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign warn_o = warn_q;
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int GRAN_BITS     = 4,
  parameter int CNT_W         = 17,
  parameter int WARN_INTERVAL = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_uncached_i,
  input  logic              inval_i,
  output logic              res_valid_o,
  output logic              issue_ok_o,
  output logic [1:0]        result_o,
  output logic              livelock_warn_o
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic             is_resv, is_cond;
  logic [TAG_W-1:0] req_tag, resv_tag;
  logic             live, pass;
  logic [1:0]       code;
  logic             valid_q, issue_q;
  logic [1:0]       code_q;

  assign is_resv = req_valid_i && (lrsc_op_e'(req_op_i) == OP_RESERVE);
  assign is_cond = req_valid_i && (lrsc_op_e'(req_op_i) == OP_COND);
  assign req_tag = req_addr_i[ADDR_W-1:GRAN_BITS];

  lrsc_resv #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) resv_i (
    .clk(clk), .rst(rst),
    .set_i(is_resv), .set_tag_i(req_tag),
    .kill_i(inval_i || is_cond),
    .live_o(live), .tag_o(resv_tag)
  );

  lrsc_judge #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) judge_i (
    .live_i(live), .resv_tag_i(resv_tag), .req_tag_i(req_tag),
    .uncached_i(req_uncached_i), .inval_i(inval_i),
    .pass_o(pass), .code_o(code)
  );

  lrsc_fail_cnt #(.CNT_W(CNT_W), .WARN_INTERVAL(WARN_INTERVAL)) fcnt_i (
    .clk(clk), .rst(rst),
    .fail_i(is_cond && !pass),
    .clear_i(is_cond && pass),
    .warn_o(livelock_warn_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      issue_q <= 1'b0;
      code_q  <= RES_FAIL;
    end else begin
      valid_q <= is_cond;
      issue_q <= is_cond && pass;
      code_q  <= is_cond ? code : RES_FAIL;
    end
  end

  assign res_valid_o = valid_q;
  assign issue_ok_o  = issue_q;
  assign result_o    = code_q;
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic              req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_uncached_i,
  input logic              inval_i,
  input logic              res_valid_o,
  input logic              issue_ok_o,
  input logic [1:0]        result_o,
  input logic              livelock_warn_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!res_valid_o && !issue_ok_o && !livelock_warn_o));

  assert_fail_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && result_o == 2'd0) |-> !issue_ok_o);

  assert_issue_code_R2: assert property (@(posedge clk) disable iff (rst)
    issue_ok_o |-> (res_valid_o && result_o != 2'd0));

  assert_cond_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_op_i) |=> res_valid_o);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    !(req_valid_i && req_op_i) |=> (!res_valid_o && result_o == 2'd0));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_op_i && req_uncached_i) |=> (issue_ok_o && result_o == 2'd2));

  assert_inval_first_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_op_i && !req_uncached_i && inval_i) |=> (result_o == 2'd0));

  assert_warn_with_fail_R8: assert property (@(posedge clk) disable iff (rst)
    livelock_warn_o |-> (res_valid_o && result_o == 2'd0));

  assert_warn_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    livelock_warn_o |=> !livelock_warn_o);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
  .req_addr_i(req_addr_i), .req_uncached_i(req_uncached_i), .inval_i(inval_i),
  .res_valid_o(res_valid_o), .issue_ok_o(issue_ok_o), .result_o(result_o),
  .livelock_warn_o(livelock_warn_o)
);

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb_top;
  localparam int AW = 32;
  localparam int INTV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_op = 1'b0, req_unc = 1'b0, inval = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic res_valid, issue_ok, warn;
  logic [1:0] result;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lrsc_monitor #(.ADDR_W(AW), .GRAN_BITS(4), .CNT_W(4), .WARN_INTERVAL(INTV)) dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_uncached_i(req_unc), .inval_i(inval),
    .res_valid_o(res_valid), .issue_ok_o(issue_ok), .result_o(result),
    .livelock_warn_o(warn)
  );

  typedef struct packed {
    logic        v;
    logic        op;
    logic        unc;
    logic        inv;
    logic [31:0] addr;
    logic        e_valid;
    logic        e_issue;
    logic [1:0]  e_res;
  } vec_t;

  // op 0 = reserve, 1 = conditional; result 0 fail, 1 ok, 2 bypass
  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,32'h1000, 1'b1,1'b0,2'd0}, // R3 no reservation
    '{1'b1,1'b0,1'b0,1'b0,32'h1234, 1'b0,1'b0,2'd0}, // R7 reserve: no result
    '{1'b1,1'b1,1'b0,1'b0,32'h123C, 1'b1,1'b1,2'd1}, // R2 same granule
    '{1'b1,1'b1,1'b0,1'b0,32'h1230, 1'b1,1'b0,2'd0}, // R5 flag killed by success
    '{1'b1,1'b0,1'b0,1'b0,32'h2000, 1'b0,1'b0,2'd0},
    '{1'b1,1'b1,1'b0,1'b0,32'h2010, 1'b1,1'b0,2'd0}, // R4 other granule
    '{1'b1,1'b1,1'b0,1'b0,32'h2000, 1'b1,1'b0,2'd0}, // R4 flag killed by failure
    '{1'b1,1'b0,1'b0,1'b0,32'h3000, 1'b0,1'b0,2'd0},
    '{1'b1,1'b0,1'b0,1'b0,32'h4008, 1'b0,1'b0,2'd0}, // R11 replace
    '{1'b1,1'b1,1'b0,1'b0,32'h3000, 1'b1,1'b0,2'd0}, // R11 old granule fails
    '{1'b1,1'b0,1'b0,1'b0,32'h4000, 1'b0,1'b0,2'd0},
    '{1'b1,1'b1,1'b1,1'b0,32'h9999, 1'b1,1'b1,2'd2}, // R6 bypass
    '{1'b1,1'b1,1'b0,1'b0,32'h4000, 1'b1,1'b0,2'd0}, // R6 bypass killed flag
    '{1'b1,1'b1,1'b1,1'b0,32'h0040, 1'b1,1'b1,2'd2}, // R6 bypass, no flag
    '{1'b1,1'b0,1'b0,1'b1,32'h5000, 1'b0,1'b0,2'd0}, // R10 reserve with inval
    '{1'b1,1'b1,1'b0,1'b0,32'h500F, 1'b1,1'b1,2'd1}, // R10 reserve survived
    '{1'b1,1'b0,1'b0,1'b0,32'h6000, 1'b0,1'b0,2'd0},
    '{1'b1,1'b1,1'b0,1'b1,32'h6000, 1'b1,1'b0,2'd0}, // R10 cond with inval
    '{1'b1,1'b0,1'b0,1'b0,32'h7000, 1'b0,1'b0,2'd0},
    '{1'b0,1'b0,1'b0,1'b1,32'h0000, 1'b0,1'b0,2'd0}, // R10 idle inval
    '{1'b1,1'b1,1'b0,1'b0,32'h7000, 1'b1,1'b0,2'd0}  // R10 flag gone
  };

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic apply(logic v, logic op, logic unc, logic inv, logic [AW-1:0] a);
    @(negedge clk);
    req_valid = v; req_op = op; req_unc = unc; inval = inv; req_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; inval = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 outputs in reset", {res_valid, issue_ok, warn, result[0]}, 4'h0);
    do_reset();
    @(posedge clk); #1;
    chk("R1 outputs after reset", {res_valid, issue_ok, result}, 4'h0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].v, TBL[i].op, TBL[i].unc, TBL[i].inv, TBL[i].addr);
      chk($sformatf("R2-table row %0d", i),
          {res_valid, issue_ok, TBL[i].e_res == result ? 2'b00 : 2'b11},
          {TBL[i].e_valid, TBL[i].e_issue, 2'b00});
      chk($sformatf("R8 no warn row %0d", i), {3'b0, warn}, 4'h0);
    end
    apply(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R7 idle after table", {res_valid, issue_ok, result}, 4'h0);

    // R1: reset drops a live reservation
    apply(1'b1, 1'b0, 1'b0, 1'b0, 32'h8000);
    do_reset();
    apply(1'b1, 1'b1, 1'b0, 1'b0, 32'h8000);
    chk("R1 reservation cleared by reset", {res_valid, issue_ok, result}, 4'b1000);

    // R8/R9: counter is now 1; drive 16 more failures (totals 2..17)
    for (int k = 2; k <= 17; k++) begin
      apply(1'b1, 1'b1, 1'b0, 1'b0, 32'h8000);
      if (k == 16 || k == 17)
        chk($sformatf("R9 saturated count %0d", k), {3'b0, warn}, 4'h0);
      else
        chk($sformatf("R8 count %0d", k), {3'b0, warn}, {3'b0, (k % INTV) == 0});
    end

    // R5: a success resets the counter; the 5th failure afterwards warns
    apply(1'b1, 1'b0, 1'b0, 1'b0, 32'hA000);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 32'hA004);
    chk("R5 success", {res_valid, issue_ok, result}, 4'b1101);
    for (int k = 1; k <= INTV; k++) begin
      apply(1'b1, 1'b1, 1'b0, 1'b0, 32'hA000);
      chk($sformatf("R5 recount %0d", k), {3'b0, warn}, {3'b0, k == INTV});
    end
    apply(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R8 warn is one cycle", {3'b0, warn}, 4'h0);

    // R6: a bypass resets the counter too
    for (int k = 1; k <= 3; k++) apply(1'b1, 1'b1, 1'b0, 1'b0, 32'hA000);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 32'hB000);
    chk("R6 bypass code", {res_valid, issue_ok, result}, 4'b1110);
    for (int k = 1; k <= INTV; k++) begin
      apply(1'b1, 1'b1, 1'b0, 1'b0, 32'hA000);
      chk($sformatf("R6 counter cleared %0d", k), {3'b0, warn}, {3'b0, k == INTV});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule